// File: doc/BRIEF.md
# Ratio-Checked Multi-Domain Strobe Generator

This block runs from one master clock and produces single-cycle clock-enable strobes for four derived domains: a memory bus domain, a peripheral bus domain, a debug/trace domain and a control-processor domain. The memory bus strobe divides the master clock by N, where N runs from 1 to 16. Each of the other three domains runs either at the memory bus rate or at half of it.

A configuration write carries all four settings in one step. The block checks every write against the ratio rules. The debug/trace and control-processor domains must never run slower than the peripheral bus. A write that breaks this rule is dropped and raises a sticky error. A write that passes is held as pending. It takes effect only on a cycle where every domain strobe fires together, so every slower strobe always coincides with a memory bus strobe.

Two reference ticks run beside the strobes, each at one twenty-fourth of its own source clock. The first comes from the master clock and the second from a separate reference clock. Neither depends on the divider settings. The single active-low reset is asserted asynchronously and released synchronously in each clock domain.

Top module: `domain_strobe_gen`

## Requirements
- R1: With divider field D (0..15), `en_mem_o` is high for exactly one master cycle in every D+1 cycles. At D=0 it stays high continuously.
- R2: For each of the peripheral, debug and control-processor domains, a half bit of 0 makes its strobe equal `en_mem_o`. A half bit of 1 makes it fire on every second memory strobe, namely on the last cycle of each 2(D+1)-cycle frame.
- R3: A write with `cfg_per_half_i`=0 and either `cfg_dbg_half_i`=1 or `cfg_cpu_half_i`=1 is refused. Both the active and the pending configuration remain unchanged.
- R4: A refused write sets `cfg_err_o` from the next cycle on, and the flag holds until a cycle with `err_clr_i`=1. If a refusal and a clear fall on the same cycle, the flag is set.
- R5: An accepted write raises `cfg_pend_o` on the next cycle. The new setting becomes active at the first later cycle on which all four strobes are high. The frame restarts after that cycle, and `cfg_pend_o` drops.
- R6: A second accepted write while one is pending replaces the pending setting. A refused write leaves the pending setting as it was.
- R7: `ref_tick_o` is high for one master cycle in every 24. The first tick comes 24 cycles after the internal reset release, whatever the configuration.
- R8: `ref2_tick_o` is high for one `clk_ref2_i` cycle in every 24. Its counter runs entirely in that clock's domain.
- R9: After reset, all domains run at divide-by-1 with every half bit clear. In that state all four strobes are high and `cfg_pend_o`, `cfg_err_o` and both ticks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| clk_ref2_i | input | 1 | Second reference source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mem_div_i | input | 4 | Memory bus divisor minus one |
| cfg_per_half_i | input | 1 | Peripheral bus at half memory rate |
| cfg_dbg_half_i | input | 1 | Debug/trace domain at half memory rate |
| cfg_cpu_half_i | input | 1 | Control-processor domain at half memory rate |
| err_clr_i | input | 1 | Clears the sticky error flag |
| en_mem_o | output | 1 | Memory bus clock enable |
| en_per_o | output | 1 | Peripheral bus clock enable |
| en_dbg_o | output | 1 | Debug/trace clock enable |
| en_cpu_o | output | 1 | Control-processor clock enable |
| cfg_pend_o | output | 1 | Accepted setting waiting for alignment |
| cfg_err_o | output | 1 | Sticky refused-write flag |
| ref_tick_o | output | 1 | Master clock divided by 24 tick |
| ref2_tick_o | output | 1 | Second reference clock divided by 24 tick, in its domain |

## Verification
The bench goes after switches requested in the middle of a frame. A design that switched at once would put a half-rate strobe off a memory strobe, or cut a period short. It drives refused writes with a pending setting in flight, where a faulty guard would corrupt the pending value or let it through. It also covers back-to-back accepted writes, where the last one must win, and a refusal arriving together with a clear, where a wrong priority would leave the error flag low. Divide-by-1 with half domains and divide-by-16 exercise the ends of the frame counter, where an off-by-one shows up as a stuck or missing strobe. The reference ticks are compared across every reconfiguration, so a tick counter wrongly tied to the frame restart would drift.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  localparam int unsigned DIV_W = 4;
  localparam int unsigned CNT_W = DIV_W + 1;
  localparam int unsigned NSUB  = 3;

  typedef struct packed {
    logic [DIV_W-1:0] mem_div;
    logic             per_half;
    logic             dbg_half;
    logic             cpu_half;
  } dom_cfg_t;

  localparam dom_cfg_t CFG_RESET = '{mem_div: '0, per_half: 1'b0,
                                     dbg_half: 1'b0, cpu_half: 1'b0};

  // Debug and control-processor domains may not be slower than the peripheral bus.
  function automatic logic cfg_legal(dom_cfg_t c);
    return c.per_half || !(c.dbg_half || c.cpu_half);
  endfunction
endpackage

// File: rtl/dsg_rst_sync.sv
module dsg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dsg_ref_tick.sv
module dsg_ref_tick #(
  parameter int unsigned DIV = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = $clog2(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  // R7 / R8: a tick never lasts two cycles and the count stays in range
  a_r7_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r8_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/dsg_cfg_guard.sv
module dsg_cfg_guard
  import dsg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  dom_cfg_t wr_cfg_i,
  input  logic     err_clr_i,
  input  logic     all_fire_i,
  output dom_cfg_t act_cfg_o,
  output logic     apply_o,
  output logic     pend_o,
  output logic     err_o
);
  dom_cfg_t act_q, act_d;
  dom_cfg_t pcfg_q, pcfg_d;
  logic     pend_q, pend_d;
  logic     err_q, err_d;
  logic     legal, accept, reject, apply;

  always_comb begin
    legal  = cfg_legal(wr_cfg_i);
    accept = we_i && legal;
    reject = we_i && !legal;
    apply  = pend_q && all_fire_i;

    act_d  = apply ? pcfg_q : act_q;
    pcfg_d = accept ? wr_cfg_i : pcfg_q;
    if (accept)     pend_d = 1'b1;
    else if (apply) pend_d = 1'b0;
    else            pend_d = pend_q;
    if (reject)         err_d = 1'b1;
    else if (err_clr_i) err_d = 1'b0;
    else                err_d = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= CFG_RESET;
      pcfg_q <= CFG_RESET;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      pcfg_q <= pcfg_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign act_cfg_o = act_q;
  assign apply_o   = apply;
  assign pend_o    = pend_q;
  assign err_o     = err_q;

  a_r3_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !legal && !apply) |=> ($stable(pcfg_q) && $stable(pend_q) && $stable(act_q)));
  a_r4_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !legal) |=> err_q);
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);
  a_r5_switch_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(all_fire_i));
endmodule

// File: rtl/dsg_phase_ctr.sv
module dsg_phase_ctr
  import dsg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  dom_cfg_t        act_cfg_i,
  input  logic            restart_i,
  output logic            mem_stb_o,
  output logic [NSUB-1:0] sub_stb_o,
  output logic            all_fire_o
);
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] mid_pos, end_pos;
  logic [NSUB-1:0]  half;
  logic             wrap, mem_stb;

  // index 2: peripheral, 1: debug, 0: control processor
  assign half = {act_cfg_i.per_half, act_cfg_i.dbg_half, act_cfg_i.cpu_half};

  always_comb begin
    mid_pos = {1'b0, act_cfg_i.mem_div};
    end_pos = {act_cfg_i.mem_div, 1'b1};
    wrap    = (pos_q == end_pos);
    mem_stb = (pos_q == mid_pos) || wrap;
    pos_d   = (restart_i || wrap) ? '0 : pos_q + 1'b1;
  end

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    assign sub_stb_o[g] = half[g] ? wrap : mem_stb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign mem_stb_o  = mem_stb;
  assign all_fire_o = mem_stb && (&sub_stb_o);

  a_r5_restart_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> all_fire_o);
  a_r1_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= end_pos);
endmodule

// File: rtl/domain_strobe_gen.sv
module domain_strobe_gen
  import dsg_pkg::*;
#(
  parameter int unsigned REF_DIV  = 24,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic             clk_i,
  input  logic             clk_ref2_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [DIV_W-1:0] cfg_mem_div_i,
  input  logic             cfg_per_half_i,
  input  logic             cfg_dbg_half_i,
  input  logic             cfg_cpu_half_i,
  input  logic             err_clr_i,
  output logic             en_mem_o,
  output logic             en_per_o,
  output logic             en_dbg_o,
  output logic             en_cpu_o,
  output logic             cfg_pend_o,
  output logic             cfg_err_o,
  output logic             ref_tick_o,
  output logic             ref2_tick_o
);
  logic            rst_main_n, rst_ref2_n;
  dom_cfg_t        wr_cfg, act_cfg;
  logic            apply, all_fire, mem_stb;
  logic [NSUB-1:0] sub_stb;

  dsg_rst_sync #(.STAGES(SYNC_LEN)) u_rst_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_main_n));
  dsg_rst_sync #(.STAGES(SYNC_LEN)) u_rst_ref2 (
    .clk_i(clk_ref2_i), .rst_ni(rst_ni), .rst_no(rst_ref2_n));

  always_comb begin
    wr_cfg.mem_div  = cfg_mem_div_i;
    wr_cfg.per_half = cfg_per_half_i;
    wr_cfg.dbg_half = cfg_dbg_half_i;
    wr_cfg.cpu_half = cfg_cpu_half_i;
  end

  dsg_cfg_guard u_guard (
    .clk_i(clk_i), .rst_ni(rst_main_n), .we_i(cfg_we_i), .wr_cfg_i(wr_cfg),
    .err_clr_i(err_clr_i), .all_fire_i(all_fire), .act_cfg_o(act_cfg),
    .apply_o(apply), .pend_o(cfg_pend_o), .err_o(cfg_err_o));

  dsg_phase_ctr u_phase (
    .clk_i(clk_i), .rst_ni(rst_main_n), .act_cfg_i(act_cfg), .restart_i(apply),
    .mem_stb_o(mem_stb), .sub_stb_o(sub_stb), .all_fire_o(all_fire));

  dsg_ref_tick #(.DIV(REF_DIV)) u_ref1 (
    .clk_i(clk_i), .rst_ni(rst_main_n), .tick_o(ref_tick_o));
  dsg_ref_tick #(.DIV(REF_DIV)) u_ref2 (
    .clk_i(clk_ref2_i), .rst_ni(rst_ref2_n), .tick_o(ref2_tick_o));

  assign en_mem_o = mem_stb;
  assign en_per_o = sub_stb[2];
  assign en_dbg_o = sub_stb[1];
  assign en_cpu_o = sub_stb[0];

  // R2: every derived strobe lands on a memory strobe; a peripheral strobe implies the faster two
  a_r2_sub_on_mem: assert property (@(posedge clk_i) disable iff (!rst_main_n)
    (en_per_o || en_dbg_o || en_cpu_o) |-> en_mem_o);
  a_r2_per_not_faster: assert property (@(posedge clk_i) disable iff (!rst_main_n)
    en_per_o |-> (en_dbg_o && en_cpu_o));
endmodule

// File: tb/sim_domain_strobe_gen.sv
module sim_domain_strobe_gen;
  localparam int CLK_PERIOD  = 10;
  localparam int CLK2_PERIOD = 12;
  localparam int REF_DIV     = 24;

  logic clk = 1'b0, clk2 = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, per_h = 1'b0, dbg_h = 1'b0, cpu_h = 1'b0, clr = 1'b0;
  logic [3:0] div = 4'd0;
  logic en_mem, en_per, en_dbg, en_cpu, pend, err, tick1, tick2;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CLK2_PERIOD/2) clk2 = ~clk2;

  domain_strobe_gen u0 (
    .clk_i(clk), .clk_ref2_i(clk2), .rst_ni(rst_n), .cfg_we_i(we),
    .cfg_mem_div_i(div), .cfg_per_half_i(per_h), .cfg_dbg_half_i(dbg_h),
    .cfg_cpu_half_i(cpu_h), .err_clr_i(clr), .en_mem_o(en_mem), .en_per_o(en_per),
    .en_dbg_o(en_dbg), .en_cpu_o(en_cpu), .cfg_pend_o(pend), .cfg_err_o(err),
    .ref_tick_o(tick1), .ref2_tick_o(tick2));

  typedef struct packed {
    logic mem; logic per; logic dbg; logic cpu; logic pend; logic err; logic ref1;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string scen = "R9";

  task automatic chk(input string tag, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b (scenario %s)", tag, $time, act, expv, scen);
    end
  endtask

  // reference model of the master domain, from the requirements
  bit s1 = 0, s2 = 0;
  int m_div = 1, p_div = 1, m_pos = 0, m_ref = 0;
  bit m_half [3] = '{0, 0, 0};
  bit p_half [3] = '{0, 0, 0};
  bit m_pend = 0, m_err = 0;

  function automatic exp_t model_out();
    exp_t e;
    bit wrap, mem;
    wrap  = (m_pos == 2*m_div - 1);
    mem   = (m_pos == m_div - 1) || wrap;
    e.mem = mem;
    e.per = m_half[0] ? wrap : mem;
    e.dbg = m_half[1] ? wrap : mem;
    e.cpu = m_half[2] ? wrap : mem;
    e.pend = m_pend;
    e.err  = m_err;
    e.ref1 = (m_ref == REF_DIV - 1);
    return e;
  endfunction

  always @(posedge clk) begin
    bit old_s2, apply, legal, wrap;
    exp_t cur;
    old_s2 = s2;
    if (!rst_n) begin s1 = 0; s2 = 0; end
    else begin s2 = s1; s1 = 1; end
    if (!rst_n || !old_s2) begin
      m_div = 1; p_div = 1; m_pos = 0; m_ref = 0; m_pend = 0; m_err = 0;
      m_half = '{0, 0, 0}; p_half = '{0, 0, 0};
    end else begin
      cur   = model_out();
      wrap  = (m_pos == 2*m_div - 1);
      apply = m_pend && cur.mem && cur.per && cur.dbg && cur.cpu;
      legal = per_h || !(dbg_h || cpu_h);
      if (apply) begin m_div = p_div; m_half = p_half; end
      if (we && legal) begin
        p_div = int'(div) + 1; p_half = '{per_h, dbg_h, cpu_h}; m_pend = 1;
      end else if (apply) m_pend = 0;
      if (we && !legal) m_err = 1;
      else if (clr) m_err = 0;
      m_pos = (apply || wrap) ? 0 : m_pos + 1;
      m_ref = (m_ref == REF_DIV - 1) ? 0 : m_ref + 1;
    end
    sb_q.push_back(model_out());
  end

  // monitor: pops one expected item per master cycle
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk("R1 en_mem", en_mem, e.mem);
      chk("R2 en_per", en_per, e.per);
      chk("R2 en_dbg", en_dbg, e.dbg);
      chk("R2 en_cpu", en_cpu, e.cpu);
      chk("R5 pend",   pend,   e.pend);
      chk("R4 err",    err,    e.err);
      chk("R7 ref1",   tick1,  e.ref1);
    end
  end

  // second reference domain model (R8)
  bit t1 = 0, t2 = 0;
  int m_ref2 = 0;
  bit exp2 = 0;
  always @(posedge clk2) begin
    bit old_t2;
    old_t2 = t2;
    if (!rst_n) begin t1 = 0; t2 = 0; end
    else begin t2 = t1; t1 = 1; end
    if (!rst_n || !old_t2) m_ref2 = 0;
    else m_ref2 = (m_ref2 == REF_DIV - 1) ? 0 : m_ref2 + 1;
    exp2 = (m_ref2 == REF_DIV - 1);
  end
  always @(negedge clk2) begin
    #1;
    if (!done) chk("R8 ref2", tick2, exp2);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int d, input bit ph, input bit dh, input bit ch, input bit c);
    @(negedge clk);
    we = 1; div = 4'(d); per_h = ph; dbg_h = dh; cpu_h = ch; clr = c;
    @(negedge clk);
    we = 0; clr = 0;
  endtask

  task automatic clear_err();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R9: outputs in reset
    chk("R9 reset mem", en_mem, 1'b1);
    chk("R9 reset per", en_per, 1'b1);
    chk("R9 reset pend", pend, 1'b0);
    chk("R9 reset err", err, 1'b0);
    chk("R9 reset ref", tick1, 1'b0);
    rst_n = 1;
    idle(60);
    scen = "R1 divide by 3";
    wr(2, 0, 0, 0, 0);
    idle(30);
    scen = "R2 divide by 4, per+dbg half";
    wr(3, 1, 1, 0, 0);
    idle(40);
    scen = "R3 refused write";
    wr(5, 0, 1, 0, 0);
    idle(30);
    chk("R3 err raised", err, 1'b1);
    scen = "R4 clear";
    clear_err();
    idle(5);
    chk("R4 err cleared", err, 1'b0);
    scen = "R4 set wins over clear";
    wr(1, 0, 0, 1, 1);
    idle(5);
    chk("R4 set beats clear", err, 1'b1);
    clear_err();
    scen = "R6 back-to-back, refusal while pending";
    wr(15, 1, 1, 1, 0);
    wr(6, 1, 0, 1, 0);
    wr(9, 0, 1, 1, 0);
    idle(60);
    clear_err();
    scen = "R1 divide by 16 all half";
    wr(15, 1, 1, 1, 0);
    idle(140);
    scen = "R2 divide by 1 with halves";
    wr(0, 1, 1, 1, 0);
    idle(80);
    scen = "R5 divide by 1 all full";
    wr(0, 0, 0, 0, 0);
    idle(40);
    done = 1;
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule